// File: doc/BRIEF.md
# Permutation Crossbar Scheduler with Full-Occupancy Gate

This block picks a crossbar configuration for an N-by-N switch with virtual output queues. It does not compare queue lengths. It picks one of N fixed cyclic permutations each slot. Permutation k joins input i to output (i + k) mod N.

Four modes are supported:

- Cyclic mode steps through the permutations in order, one per clock, whatever the occupancy.
- Random mode draws the permutation index from a free-running 16-bit LFSR.
- Each of the two also has a gated form. In a gated form the switch serves nothing in a slot unless every one of the N² queues holds a cell.

Queue storage sits outside the block. The block sees only one nonempty flag per queue, plus a two-bit mode select. For each slot it returns three registered results: a serve flag, the output index chosen for every input, and a per-input grant. The grant tells that input to send a cell over the connection it was given.

Top module: `perm_wuf_sched`

## Requirements
- R1: While rst_ni is low, serve_o and grant_o are all zero and every field of out_sel_o is zero. The cyclic index starts at 0 and the LFSR starts at the SEED parameter (default 16'hACE1).
- R2: With mode_i bit 0 clear, serve_o is 1 in every slot. In cyclic mode (mode_i = 0), field i of out_sel_o (bits i*IDX_W +: IDX_W) equals (i + k) mod N. Here k is the cyclic index, and it advances by one modulo N after each served slot.
- R3: grant_o[i] is 1 exactly when serve_o is 1 and the queue from input i to the output selected in field i is nonempty. The flag for input i, output j is voq_nonempty_i bit i*N + j. An input with an empty queue still keeps its connection in out_sel_o.
- R4: In a gated mode (mode_i bit 0 set), if any flag of voq_nonempty_i is 0, the following slot has serve_o = 0 and grant_o = 0.
- R5: In gated cyclic mode (mode_i = 1), the cyclic index does not advance in a slot that serves nothing. out_sel_o shows the held permutation in that slot.
- R6: In a gated mode with every flag set, serve_o = 1 and every grant_o bit is 1.
- R7: In random modes (mode_i bit 1 set), k for the slot is the current LFSR value mod N. The LFSR shifts left each clock, taking in bit 15 ^ bit 13 ^ bit 12 ^ bit 10 at bit 0. Random modes leave the cyclic index unchanged.
- R8: Outputs are registered. Inputs sampled at one rising edge determine serve_o, grant_o and out_sel_o from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bit 0: gate on full occupancy; bit 1: random permutation pick |
| voq_nonempty_i | input | N*N | Queue nonempty flags; bit i*N+j is input i to output j |
| serve_o | output | 1 | The slot serves through the chosen permutation |
| out_sel_o | output | N*IDX_W | Output index chosen for each input, field i at i*IDX_W |
| grant_o | output | N | Input i sends a cell this slot |

## Verification
The assertions assume only that mode_i and voq_nonempty_i hold known values at each rising edge. They relate those sampled values to the registered outputs one edge later. The bench changes inputs only at falling edges, so every sample is settled. It sweeps each single-empty-queue pattern in both gated modes, so the gate is tested one bit away from full occupancy. It then switches modes back and forth, so the held cyclic index is seen across random and gated stretches.

// File: rtl/perm_wuf_sched_pkg.sv
package perm_wuf_sched_pkg;
  typedef enum logic [1:0] {
    MODE_CYCLIC       = 2'd0,
    MODE_CYCLIC_GATED = 2'd1,
    MODE_RANDOM       = 2'd2,
    MODE_RANDOM_GATED = 2'd3
  } sched_mode_e;

  localparam int unsigned LFSR_W = 16;
endpackage

// File: rtl/xbs_lfsr.sv
module xbs_lfsr
  import perm_wuf_sched_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign state_o = state_q;

  // R7: a maximal-length register never reaches the all-zero lockup state
  a_r7_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/xbs_perm.sv
module xbs_perm #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [IDX_W-1:0]   shift_i,
  output logic [N*IDX_W-1:0] sel_o
);
  localparam int unsigned SUM_W = IDX_W + 1;

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;
    assign sum     = SUM_W'(i) + {1'b0, shift_i};
    assign wrapped = (sum >= SUM_W'(N)) ? (sum - SUM_W'(N)) : sum;
    assign sel_o[i*IDX_W +: IDX_W] = wrapped[IDX_W-1:0];
  end
endmodule

// File: rtl/xbs_gate.sv
module xbs_gate #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N*N-1:0]     voq_nonempty_i,
  input  logic               gated_i,
  input  logic [N*IDX_W-1:0] sel_i,
  output logic               serve_o,
  output logic [N-1:0]       grant_o
);
  logic all_full;

  assign all_full = &voq_nonempty_i;
  assign serve_o  = !gated_i || all_full;

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0]     row;
    logic [IDX_W-1:0] sel;
    assign row        = voq_nonempty_i[i*N +: N];
    assign sel        = sel_i[i*IDX_W +: IDX_W];
    assign grant_o[i] = serve_o && row[sel];
  end
endmodule

// File: rtl/perm_wuf_sched.sv
module perm_wuf_sched
  import perm_wuf_sched_pkg::*;
#(
  parameter int unsigned       N     = 4,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
  parameter int unsigned       IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [N*N-1:0]     voq_nonempty_i,
  output logic               serve_o,
  output logic [N*IDX_W-1:0] out_sel_o,
  output logic [N-1:0]       grant_o
);
  localparam logic [IDX_W-1:0] K_LAST = IDX_W'(N - 1);

  sched_mode_e       mode;
  logic              gated, random_pick;
  logic [LFSR_W-1:0] lfsr;
  logic [IDX_W-1:0]  k_q, k_next, shift;
  logic [N*IDX_W-1:0] sel_d;
  logic              serve_d;
  logic [N-1:0]      grant_d;

  assign mode        = sched_mode_e'(mode_i);
  assign gated       = mode_i[0];
  assign random_pick = mode_i[1];

  xbs_lfsr #(.SEED(SEED)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(lfsr)
  );

  assign shift = random_pick ? IDX_W'(lfsr % LFSR_W'(N)) : k_q;

  xbs_perm #(.N(N), .IDX_W(IDX_W)) i_perm (
    .shift_i(shift),
    .sel_o  (sel_d)
  );

  xbs_gate #(.N(N), .IDX_W(IDX_W)) i_gate (
    .voq_nonempty_i(voq_nonempty_i),
    .gated_i       (gated),
    .sel_i         (sel_d),
    .serve_o       (serve_d),
    .grant_o       (grant_d)
  );

  // cyclic index moves only on served cyclic slots
  always_comb begin
    k_next = k_q;
    if (!random_pick && serve_d) k_next = (k_q == K_LAST) ? '0 : k_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q       <= '0;
      serve_o   <= 1'b0;
      out_sel_o <= '0;
      grant_o   <= '0;
    end else begin
      k_q       <= k_next;
      serve_o   <= serve_d;
      out_sel_o <= sel_d;
      grant_o   <= grant_d;
    end
  end

  a_r2_ungated_serves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[0] |=> serve_o);

  a_r3_grant_needs_serve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serve_o |-> (grant_o == '0));

  a_r4_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[0] && !(&voq_nonempty_i)) |=> (!serve_o && grant_o == '0));

  a_r5_index_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_CYCLIC_GATED && !(&voq_nonempty_i)) |=> $stable(k_q));

  a_r6_full_serves_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[0] && (&voq_nonempty_i)) |=> (serve_o && (&grant_o)));

  a_r7_random_keeps_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |=> $stable(k_q));
endmodule

// File: tb/test_perm_wuf_sched.sv
module test_perm_wuf_sched;
  localparam int N     = 4;
  localparam int IDX_W = 2;
  localparam logic [15:0] SEED = 16'hACE1;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [N*N-1:0]   voq = '0;
  logic             serve;
  logic [N*IDX_W-1:0] sel;
  logic [N-1:0]     grant;

  int checks = 0;
  int failures = 0;
  int k_m = 0;
  logic [15:0] lfsr_m = SEED;
  bit done = 0;

  always #5 clk = ~clk;

  perm_wuf_sched #(.N(N), .SEED(SEED)) i_perm_wuf_sched (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .voq_nonempty_i(voq),
    .serve_o(serve), .out_sel_o(sel), .grant_o(grant)
  );

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge: drive, model, clock, sample at next falling edge
  task automatic step(logic [1:0] m, logic [N*N-1:0] v, string req);
    logic exp_serve;
    logic [N*IDX_W-1:0] exp_sel;
    logic [N-1:0] exp_grant;
    int kk;
    mode = m;
    voq  = v;
    exp_serve = !m[0] || (&v);
    kk = m[1] ? int'(lfsr_m % 16'(N)) : k_m;
    for (int i = 0; i < N; i++) begin
      int j;
      j = (i + kk) % N;
      exp_sel[i*IDX_W +: IDX_W] = IDX_W'(j);
      exp_grant[i] = exp_serve && v[i*N + j];
    end
    if (!m[1] && exp_serve) k_m = (k_m + 1) % N;
    lfsr_m = lfsr_next(lfsr_m);
    @(posedge clk);
    @(negedge clk);
    check({req, " serve"}, 32'(serve), 32'(exp_serve));
    check({req, " sel"},   32'(sel),   32'(exp_sel));
    check({req, " grant"}, 32'(grant), 32'(exp_grant));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N*N-1:0] pat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 serve", 32'(serve), 0);
    check("R1 sel",   32'(sel),   0);
    check("R1 grant", 32'(grant), 0);
    rst_ni = 1'b1;

    // R2 R3 R8 cyclic mode, full then sparse patterns
    for (int c = 0; c < 2*N; c++) step(2'd0, '1, "R2");
    for (int c = 0; c < 24; c++) begin
      pat = 16'(c * 16'h9E37 + 16'h1234);
      step(2'd0, pat, "R3");
    end
    step(2'd0, '0, "R3 all-empty");

    // R4 R5 gated cyclic: every single-empty pattern
    for (int b = 0; b < N*N; b++) begin
      pat = '1;
      pat[b] = 1'b0;
      step(2'd1, pat, "R4 R5");
    end
    // R6 full occupancy in gated cyclic mode, index resumes
    for (int c = 0; c < N+1; c++) step(2'd1, '1, "R6");
    step(2'd1, 16'h0001, "R4 sparse");
    step(2'd1, '1, "R5 resume");

    // R7 random modes
    for (int c = 0; c < 20; c++) begin
      pat = 16'(c * 16'h7A1F);
      step(2'd2, pat, "R7");
    end
    for (int b = 0; b < N*N; b++) begin
      pat = '1;
      pat[b] = 1'b0;
      step(2'd3, pat, "R4 random-gated");
      step(2'd3, '1, "R6 random-gated");
    end
    // R7 random stretch leaves cyclic index as it was
    step(2'd0, '1, "R7 index kept");
    step(2'd0, 16'hA5A5, "R3 after modes");

    // R1 reset again mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    check("R1 async serve", 32'(serve), 0);
    check("R1 async grant", 32'(grant), 0);
    k_m = 0;
    lfsr_m = SEED;
    @(negedge clk);
    rst_ni = 1'b1;
    step(2'd0, '1, "R1 index restart");
    step(2'd2, '1, "R1 seed restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule